// File: doc/BRIEF.md
# Merging Store Buffer for a Write-Through Cache

This block sits between a processor's store path and the lower-level memory of a write-through cache system. The processor posts word stores into it and carries on without waiting for memory. The buffer keeps a small number of pending block-sized entries and writes them to memory in the background, one block per transfer, in arrival order. Stores tend to come in bursts, so the buffer has several entries instead of a single holding register.

A store to a block that already has a queued entry is written into that entry, and no new slot is used. This keeps the buffer from filling, which is the only condition that stalls the store port. The one exception is the entry at the head of the queue, which is being offered to memory. It is closed to further stores. Addresses inside a configurable I/O window are never merged: every such store takes its own entry.

A load probes the buffer before it goes to memory. If the youngest pending entry for the load's block holds the requested word, the word is returned directly from the buffer. If a matching entry exists but lacks that word, the load must wait until the entry has drained. With no match, the load may go to memory at once.

Top module: `merge_wbuf`

## Requirements
- R1: After synchronous reset the buffer is empty: `mem_valid` is 0, `st_ready` is 1, and a probe reports neither forward nor wait.
- R2: The store port takes a word when `st_valid` and `st_ready` are both high. `st_ready` is low only when all DEPTH entries are occupied and the store has no merge target.
- R3: A non-I/O store whose block (address bits 31:4) matches an occupied entry other than the head is merged. Word `addr[3:2]` of that entry is overwritten, its mask bit is set, and no entry is added.
- R4: A store whose block matches only the head entry allocates a new entry. While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_mask` hold steady.
- R5: A store with `(addr & IO_MASK) == IO_BASE` never merges. It always allocates a new entry, and it stalls when the buffer is full.
- R6: Entries drain in allocation order, one per cycle in which `mem_valid` and `mem_ready` are both high. `mem_addr` is the block base (low 4 bits zero). Word i sits in `mem_data[32i+31:32i]`. `mem_mask` bit i marks word i as written, and words that were never written read as zero.
- R7: When `rd_valid` is high and the youngest occupied entry matching the probe's block has the word `rd_addr[3:2]` set in its mask, `rd_fwd` is 1 and `rd_data` is that word.
- R8: When a matching entry exists but the youngest one lacks the requested word, `rd_wait` is 1 and `rd_fwd` is 0.
- R9: A probe with no matching entry gives `rd_fwd` = 0 and `rd_wait` = 0. Probes see only the contents before the current clock edge, so a store in the same cycle is not visible.
- R10: A store with a merge target is accepted even when all entries are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | 32 | Store byte address, word aligned |
| st_data | input | 32 | Store word |
| rd_valid | input | 1 | Load probe request |
| rd_addr | input | 32 | Load byte address, word aligned |
| rd_fwd | output | 1 | Word supplied by the buffer |
| rd_wait | output | 1 | Load must hold until the matching entry drains |
| rd_data | output | 32 | Forwarded word, zero when `rd_fwd` is low |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory takes the head entry |
| mem_addr | output | 32 | Block base address |
| mem_data | output | 128 | Block data, word i at bits 32i+31:32i |
| mem_mask | output | 4 | Per-word write enables |

## Verification
The in-line assertions check several properties on every cycle. The head transfer stays frozen under backpressure, the occupancy never exceeds the depth, and a drained block always carries at least one written word. A store never has more than one merge target, an I/O store never merges, and a probe never reports forward and wait together. Whether the merged words, the FIFO order, the stall decision and the forwarded data are correct is shown only by the bench. It runs a queue-based model next to the design and compares every output on every cycle, both in directed cases (head closed to merging, full buffer with a merge, I/O stores) and in a long random mix of stores, probes and memory backpressure.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = WSEL_W + $clog2(DATA_W / 8);
    localparam int BLK_W  = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [WSEL_W-1:0] wsel_t;

    typedef struct packed {
        blk_t                   blk;
        logic [WORDS-1:0]       mask;
        word_t [WORDS-1:0]      data;
    } entry_t;

    function automatic blk_t blk_of(addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic wsel_t wsel_of(addr_t a);
        return a[OFF_W-1:OFF_W-WSEL_W];
    endfunction
endpackage

// File: rtl/wbuf_io_decode.sv
module wbuf_io_decode
    import wbuf_pkg::*;
#(
    parameter addr_t IO_BASE = 32'hF000_0000,
    parameter addr_t IO_MASK = 32'hF000_0000
) (
    input  addr_t addr,
    output logic  is_io
);
    assign is_io = (addr & IO_MASK) == IO_BASE;
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  entry_t           ent [DEPTH],
    input  logic [PTR_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  logic             st_valid,
    input  blk_t             st_blk,
    input  logic             st_io,
    input  logic             rd_valid,
    input  blk_t             rd_blk,
    input  wsel_t            rd_w,
    output logic             merge_hit,
    output logic [PTR_W-1:0] merge_idx,
    output logic             rd_fwd,
    output logic             rd_wait,
    output word_t            rd_data
);
    logic [DEPTH-1:0] merge_vec;

    always_comb begin
        logic             found;
        logic [PTR_W-1:0] idx;
        entry_t           young;
        merge_vec = '0;
        merge_idx = '0;
        found     = 1'b0;
        young     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PTR_W'(k);
            if (k < int'(count)) begin
                // head (k == 0) is on the memory port and closed to stores
                if (k != 0 && st_valid && !st_io && ent[idx].blk == st_blk) begin
                    merge_vec[idx] = 1'b1;
                    merge_idx      = idx;
                end
                // later k is younger, so the last match wins
                if (rd_valid && ent[idx].blk == rd_blk) begin
                    found = 1'b1;
                    young = ent[idx];
                end
            end
        end
        merge_hit = |merge_vec;
        rd_fwd    = found && young.mask[rd_w];
        rd_wait   = found && !young.mask[rd_w];
        rd_data   = rd_fwd ? young.data[rd_w] : '0;
    end

    // R3: at most one entry can take a merging store
    a_r3_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(merge_vec));
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import wbuf_pkg::*;
#(
    parameter int    DEPTH   = 4,
    parameter addr_t IO_BASE = 32'hF000_0000,
    parameter addr_t IO_MASK = 32'hF000_0000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    input  logic                    rd_valid,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_fwd,
    output logic                    rd_wait,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORDS*DATA_W-1:0] mem_data,
    output logic [WORDS-1:0]        mem_mask
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    entry_t           ent [DEPTH];
    logic [PTR_W-1:0] head, tail, merge_idx;
    logic [CNT_W-1:0] count;
    logic             st_io, merge_hit, full, do_push, do_merge, do_pop;
    entry_t           fresh;
    wsel_t            st_w;
    logic             unused_lo;

    assign unused_lo = ^{st_addr[OFF_W-WSEL_W-1:0], rd_addr[OFF_W-WSEL_W-1:0]};

    wbuf_io_decode #(.IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) u_io (
        .addr  (st_addr),
        .is_io (st_io)
    );

    wbuf_match #(.DEPTH(DEPTH)) u_match (
        .clk       (clk),
        .rst       (rst),
        .ent       (ent),
        .head      (head),
        .count     (count),
        .st_valid  (st_valid),
        .st_blk    (blk_of(st_addr)),
        .st_io     (st_io),
        .rd_valid  (rd_valid),
        .rd_blk    (blk_of(rd_addr)),
        .rd_w      (wsel_of(rd_addr)),
        .merge_hit (merge_hit),
        .merge_idx (merge_idx),
        .rd_fwd    (rd_fwd),
        .rd_wait   (rd_wait),
        .rd_data   (rd_data)
    );

    assign st_w      = wsel_of(st_addr);
    assign full      = count == CNT_W'(DEPTH);
    assign st_ready  = merge_hit || !full;
    assign do_merge  = st_valid && merge_hit;
    assign do_push   = st_valid && !merge_hit && !full;
    assign mem_valid = count != '0;
    assign do_pop    = mem_valid && mem_ready;
    assign mem_addr  = {ent[head].blk, {OFF_W{1'b0}}};
    assign mem_data  = ent[head].data;
    assign mem_mask  = ent[head].mask;

    always_comb begin
        fresh             = '0;
        fresh.blk         = blk_of(st_addr);
        fresh.mask[st_w]  = 1'b1;
        fresh.data[st_w]  = st_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            if (do_merge) begin
                ent[merge_idx].data[st_w] <= st_data;
                ent[merge_idx].mask[st_w] <= 1'b1;
            end
            if (do_push) begin
                ent[tail] <= fresh;
                tail      <= tail + 1'b1;
            end
            if (do_pop) head <= head + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    a_r4_head_frozen: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_data) && $stable(mem_mask));

    a_r5_io_no_merge: assert property (@(posedge clk) disable iff (rst)
        st_valid && st_io |-> !merge_hit);

    a_r6_mask_nonzero: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_mask != '0);

    a_r8_fwd_wait_excl: assert property (@(posedge clk) disable iff (rst)
        !(rd_fwd && rd_wait));
endmodule

// File: tb/tb_merge_wbuf.sv
module tb_merge_wbuf;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam logic [31:0] IO_BASE = 32'hF000_0000;
    localparam logic [31:0] IO_MASK = 32'hF000_0000;

    logic         clk = 1'b0;
    logic         rst;
    logic         st_valid, st_ready, rd_valid, rd_fwd, rd_wait;
    logic         mem_valid, mem_ready;
    logic [31:0]  st_addr, st_data, rd_addr, rd_data, mem_addr;
    logic [127:0] mem_data;
    logic [3:0]   mem_mask;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [27:0]  q_blk[$];
    logic [127:0] q_dat[$];
    logic [3:0]   q_msk[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    merge_wbuf #(.DEPTH(DEPTH), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_fwd(rd_fwd), .rd_wait(rd_wait),
        .rd_data(rd_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_mask(mem_mask)
    );

    function automatic bit is_io(logic [31:0] a);
        return (a & IO_MASK) == IO_BASE;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // one clock: compare all outputs with the model, then advance the model
    task automatic cyc();
        int  mi, yi, n;
        bit  e_rdy, e_mv, e_f, e_pop, take;
        logic [1:0] w;
        #1;
        n  = q_blk.size();
        mi = -1;
        if (st_valid && !is_io(st_addr))
            for (int i = 1; i < n; i++) if (q_blk[i] == st_addr[31:4]) mi = i;
        e_rdy = (mi >= 0) || (n < DEPTH);
        chk("R2 st_ready", st_ready, e_rdy);
        e_mv = n > 0;
        chk("R6 mem_valid", mem_valid, e_mv);
        if (e_mv) begin
            chk("R6 mem_addr", mem_addr, {q_blk[0], 4'h0});
            chk("R6 mem_data", mem_data, q_dat[0]);
            chk("R6 mem_mask", mem_mask, q_msk[0]);
        end
        yi = -1;
        w  = rd_addr[3:2];
        if (rd_valid)
            for (int i = 0; i < n; i++) if (q_blk[i] == rd_addr[31:4]) yi = i;
        e_f = (yi >= 0) && q_msk[yi][w];
        chk("R7 rd_fwd", rd_fwd, e_f);
        chk("R8 rd_wait", rd_wait, (yi >= 0) && !e_f);
        if (e_f) chk("R7 rd_data", rd_data, q_dat[yi][w*32 +: 32]);
        e_pop = e_mv && mem_ready;
        take  = st_valid && e_rdy;
        @(posedge clk);
        if (take) begin
            if (mi >= 0) begin
                q_dat[mi][st_addr[3:2]*32 +: 32] = st_data;
                q_msk[mi][st_addr[3:2]] = 1'b1;
            end else begin
                q_blk.push_back(st_addr[31:4]);
                q_dat.push_back(128'(st_data) << (st_addr[3:2]*32));
                q_msk.push_back(4'b0001 << st_addr[3:2]);
            end
        end
        if (e_pop) begin
            void'(q_blk.pop_front());
            void'(q_dat.pop_front());
            void'(q_msk.pop_front());
        end
        @(negedge clk);
    endtask

    task automatic store(logic [31:0] a, logic [31:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        cyc();
        st_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; st_valid = 0; st_addr = 0; st_data = 0;
        rd_valid = 0; rd_addr = 0; mem_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset
        rd_valid = 1'b1; rd_addr = 32'h0000_1000;
        #1;
        chk("R1 st_ready", st_ready, 1);
        chk("R1 mem_valid", mem_valid, 0);
        chk("R1 rd_fwd", rd_fwd, 0);
        chk("R1 rd_wait", rd_wait, 0);
        rd_valid = 1'b0;
        cyc();

        // directed: memory stalled
        store(32'h0000_1000, 32'h11);     // entry0, becomes head
        store(32'h0000_1008, 32'h22);     // R4: head only match -> entry1
        store(32'h0000_100C, 32'h33);     // R3: merges into entry1
        rd_valid = 1'b1; rd_addr = 32'h0000_1008;
        #1; chk("R7 forward word2", rd_data, 32'h22);
        cyc();
        rd_addr = 32'h0000_1004;
        #1; chk("R8 missing word waits", rd_wait, 1);
        cyc();
        rd_addr = 32'h0000_1000;
        #1; chk("R4 youngest lacks word0", rd_wait, 1);
        cyc();
        rd_addr = 32'h0000_2000;
        #1; chk("R9 no match fwd", rd_fwd, 0); chk("R9 no match wait", rd_wait, 0);
        cyc();
        rd_valid = 1'b0;
        store(32'hF000_0004, 32'hA1);     // R5: io entry2
        store(32'hF000_0004, 32'hA2);     // R5: io entry3, no merge
        st_valid = 1'b1; st_addr = 32'h0000_3000; st_data = 32'h55;
        #1; chk("R2 full stall", st_ready, 0);
        cyc();
        st_addr = 32'hF000_0004; st_data = 32'hA3;
        #1; chk("R5 io stall when full", st_ready, 0);
        cyc();
        st_addr = 32'h0000_1004; st_data = 32'h44;
        #1; chk("R10 merge when full", st_ready, 1);
        cyc();
        st_valid = 1'b0;
        // stalled head must hold
        #1; chk("R4 head mask held", mem_mask, 4'b0001);
        cyc();
        mem_ready = 1'b1;
        #1; chk("R6 first out", mem_addr, 32'h0000_1000);
        cyc();
        #1; chk("R3 merged mask", mem_mask, 4'b1110);
        chk("R3 merged word1", mem_data[63:32], 32'h44);
        chk("R6 unwritten word0 zero", mem_data[31:0], 32'h0);
        cyc();
        #1; chk("R5 io entry a", mem_data[63:32], 32'hA1);
        cyc();
        #1; chk("R5 io entry b", mem_data[63:32], 32'hA2);
        cyc();
        #1; chk("R6 drained", mem_valid, 0);
        cyc();

        // random mix against the model
        for (int t = 0; t < 3000; t++) begin
            logic [31:0] ba;
            case ($urandom_range(0, 4))
                0: ba = 32'h0000_1000;
                1: ba = 32'h0000_1010;
                2: ba = 32'h0000_1020;
                3: ba = 32'hF000_0010;
                default: ba = 32'h0000_1030;
            endcase
            st_valid  = $urandom_range(0, 99) < 60;
            st_addr   = ba | (32'($urandom_range(0, 3)) << 2);
            st_data   = $urandom;
            rd_valid  = $urandom_range(0, 1);
            rd_addr   = (($urandom_range(0, 1)) ? 32'h0000_1010 : 32'h0000_1000)
                        | (32'($urandom_range(0, 3)) << 2);
            mem_ready = $urandom_range(0, 99) < 35;
            cyc();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule